// File: doc/BRIEF.md
# Lockable Watchdog Timer

A supervisory down-counter that software must service regularly. It sits on a simple single-word register bus and exposes three 16-bit registers. These are a control/status word, a reload (timeout) value, and a live count that can be read but not written. A free-running slow oscillator, asynchronous to the bus clock, paces the count. Each rising edge of the oscillator, once synchronized, is one tick. When the count passes zero, a sticky event flag is raised. Depending on a two-bit select field, the block then either pulses a reset request or holds an interrupt request.

Software services the timer with a pair of writes to the count register: a first key word followed directly by a second key word. Any other sequence does nothing. Three nested protection bits guard the configuration. While the timer runs, its mode bits, select field and reload value are frozen. A write-protect bit freezes the run/stop state. A lock bit freezes write-protect itself, and only a system reset clears the lock bit. Three system-state inputs (wait, stop, debug) pause the count unless the matching run-permission bit is set.

Top module: `wdt_locked`

## Requirements
- R1: After reset the control register reads 0x0004 (bit 2, the enable bit, is set), the reload register reads 0xFFFF and the count register reads 0xFFFF. Word addresses are 0 = control, 1 = reload, 2 = count. Control bit positions are 0 lock, 1 write-protect, 2 enable, 3 run-in-wait, 4 run-in-stop, 5 run-in-debug, 7:6 output select, 8 event flag.
- R2: Each strobe that is not already being acknowledged performs one access. The acknowledge goes high for exactly one clock in the cycle after that access, and read data is valid while the acknowledge is high.
- R3: While enable is set, writes to the reload register and to control bits 7:3 have no effect.
- R4: With enable clear, control bits 7:3 and the reload register take the written values.
- R5: While write-protect is set, a control write leaves enable unchanged. A write that clears write-protect keeps enable, and a later write can then change it.
- R6: Once lock is set, software cannot clear it and cannot change write-protect. A system reset returns control to 0x0004.
- R7: Writing the count register never changes its value directly.
- R8: On the first tick after enable rises, the count loads the reload value. Each later tick decrements it by one.
- R9: Writing 0x5555 and then 0xAAAA to the count register, with no other count write between them, makes the next tick reload the count and clears the event flag at once. A broken sequence reloads nothing.
- R10: Clearing enable and then setting it again makes the next tick reload the count.
- R11: A tick that finds the count at zero sets the event flag (bit 8) and reloads the count. The flag stays set until a control write with bit 8 set, or a valid service sequence, clears it.
- R12: A wait, stop or debug input holds the count unchanged on ticks unless its run bit (3, 4 or 5) is set.
- R13: With select = 00, expiry causes no interrupt. With select nonzero, the interrupt output follows the event flag and no reset pulse is produced.
- R14: With select = 00, each expiry produces a reset-request pulse exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_stb | input | 1 | Access strobe |
| bus_we | input | 1 | Write (1) or read (0) |
| bus_adr | input | 2 | Register word address |
| bus_wdat | input | 16 | Write data |
| bus_rdat | output | 16 | Registered read data |
| bus_ack | output | 1 | One-clock access acknowledge |
| osc_i | input | 1 | Slow oscillator, asynchronous to clk |
| wait_i | input | 1 | System wait state |
| stop_i | input | 1 | System stop state |
| dbg_i | input | 1 | System debug state |
| wdt_rst_o | output | 1 | Reset-request pulse on expiry |
| wdt_irq_o | output | 1 | Interrupt request (level) |

## Verification
The hardest states to reach are the protection corners. A lock set together with write-protect while enable is clear must leave the timer permanently stopped until reset. The event flag must also survive further ticks and be cleared only by the write-one or service paths. The stimulus reaches these through ordered control write chains and oscillator bursts of exact length. Expiry is made to land on a known tick by using small reload values such as 2 and 5. Pause behaviour is exercised by raising each system-state input during a burst, first with its run bit clear and then with it set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned ADR_W = 2;
  localparam logic [ADR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADR_W-1:0] ADR_TOUT = 2'd1;
  localparam logic [ADR_W-1:0] ADR_CNT  = 2'd2;

  localparam int unsigned B_LOCK = 0;
  localparam int unsigned B_WP   = 1;
  localparam int unsigned B_EN   = 2;
  localparam int unsigned B_RWT  = 3;
  localparam int unsigned B_RST  = 4;
  localparam int unsigned B_RDB  = 5;
  localparam int unsigned B_SEL  = 6;
  localparam int unsigned B_EVT  = 8;

  // packed MSB first so the struct bit index equals the register bit index
  typedef struct packed {
    logic       evt;
    logic [1:0] sel;
    logic       rdbg;
    logic       rstop;
    logic       rwait;
    logic       en;
    logic       wprot;
    logic       lock;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{evt: 1'b0, sel: 2'b00, rdbg: 1'b0, rstop: 1'b0,
                                 rwait: 1'b0, en: 1'b1, wprot: 1'b0, lock: 1'b0};
endpackage

// File: rtl/wdt_osc_edge.sv
module wdt_osc_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic osc_i,
  output logic tick_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], osc_i};
  end

  assign tick_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs import wdt_pkg::*; #(
  parameter int unsigned    DW   = 16,
  parameter logic [DW-1:0]  SVC0 = 16'h5555,
  parameter logic [DW-1:0]  SVC1 = 16'hAAAA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic             we,
  input  logic [ADR_W-1:0] adr,
  input  logic [DW-1:0]    wdat,
  input  logic [DW-1:0]    cnt,
  input  logic             expire,
  output logic [DW-1:0]    rdat,
  output logic             ack,
  output ctrl_t            ctrl,
  output logic [DW-1:0]    tout,
  output logic             reload_req
);
  ctrl_t         ctrl_q, ctrl_n;
  logic [DW-1:0] tout_q, rdat_q, rd_mux;
  logic          ack_q, armed_q;
  logic          acc, wr_ctrl, wr_tout, wr_cnt, svc_ok;

  assign acc     = stb & ~ack_q;
  assign wr_ctrl = acc & we & (adr == ADR_CTRL);
  assign wr_tout = acc & we & (adr == ADR_TOUT);
  assign wr_cnt  = acc & we & (adr == ADR_CNT);
  assign svc_ok  = wr_cnt & armed_q & (wdat == SVC1);

  always_comb begin
    ctrl_n = ctrl_q;
    if (wr_ctrl) begin
      ctrl_n.lock = ctrl_q.lock | wdat[B_LOCK];
      if (!ctrl_q.lock)  ctrl_n.wprot = wdat[B_WP];
      if (!ctrl_q.wprot) ctrl_n.en    = wdat[B_EN];
      if (!ctrl_q.en) begin
        ctrl_n.rwait = wdat[B_RWT];
        ctrl_n.rstop = wdat[B_RST];
        ctrl_n.rdbg  = wdat[B_RDB];
        ctrl_n.sel   = wdat[B_SEL+1:B_SEL];
      end
      if (wdat[B_EVT]) ctrl_n.evt = 1'b0;
    end
    if (svc_ok) ctrl_n.evt = 1'b0;
    if (expire) ctrl_n.evt = 1'b1;
  end

  always_comb begin
    case (adr)
      ADR_CTRL: rd_mux = DW'(ctrl_q);
      ADR_TOUT: rd_mux = tout_q;
      ADR_CNT:  rd_mux = cnt;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RST;
      tout_q  <= '1;
      rdat_q  <= '0;
      ack_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      ack_q  <= acc;
      if (acc && !we)          rdat_q  <= rd_mux;
      if (wr_tout && !ctrl_q.en) tout_q <= wdat;
      if (wr_cnt)              armed_q <= (wdat == SVC0);
    end
  end

  assign reload_req = (ctrl_n.en & ~ctrl_q.en) | svc_ok;
  assign rdat = rdat_q;
  assign ack  = ack_q;
  assign ctrl = ctrl_q;
  assign tout = tout_q;
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic          paused,
  input  logic          reload_req,
  input  logic [DW-1:0] tout,
  output logic [DW-1:0] cnt,
  output logic          expire
);
  logic [DW-1:0] cnt_q;
  logic          pend_q, step;

  assign step   = tick & en & ~paused;
  assign expire = step & ~pend_q & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '1;
      pend_q <= 1'b1;
    end else begin
      if (step) begin
        if (pend_q || cnt_q == '0) cnt_q <= tout;
        else                       cnt_q <= cnt_q - 1'b1;
      end
      if (reload_req) pend_q <= 1'b1;
      else if (step)  pend_q <= 1'b0;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdt_locked.sv
module wdt_locked import wdt_pkg::*; #(
  parameter int unsigned   DW          = 16,
  parameter int unsigned   SYNC_STAGES = 2,
  parameter logic [DW-1:0] SVC0        = 16'h5555,
  parameter logic [DW-1:0] SVC1        = 16'hAAAA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_stb,
  input  logic             bus_we,
  input  logic [ADR_W-1:0] bus_adr,
  input  logic [DW-1:0]    bus_wdat,
  output logic [DW-1:0]    bus_rdat,
  output logic             bus_ack,
  input  logic             osc_i,
  input  logic             wait_i,
  input  logic             stop_i,
  input  logic             dbg_i,
  output logic             wdt_rst_o,
  output logic             wdt_irq_o
);
  ctrl_t         ctrl_w;
  logic [DW-1:0] tout_w, cnt_w;
  logic          tick_w, expire_w, reload_w, paused_w, rst_req_q;

  wdt_osc_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .osc_i(osc_i), .tick_o(tick_w)
  );

  assign paused_w = (wait_i & ~ctrl_w.rwait) | (stop_i & ~ctrl_w.rstop) |
                    (dbg_i & ~ctrl_w.rdbg);

  wdt_regs #(.DW(DW), .SVC0(SVC0), .SVC1(SVC1)) u_regs (
    .clk(clk), .rst(rst), .stb(bus_stb), .we(bus_we), .adr(bus_adr),
    .wdat(bus_wdat), .cnt(cnt_w), .expire(expire_w), .rdat(bus_rdat),
    .ack(bus_ack), .ctrl(ctrl_w), .tout(tout_w), .reload_req(reload_w)
  );

  wdt_count #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_w), .en(ctrl_w.en), .paused(paused_w),
    .reload_req(reload_w), .tout(tout_w), .cnt(cnt_w), .expire(expire_w)
  );

  always_ff @(posedge clk) begin
    if (rst) rst_req_q <= 1'b0;
    else     rst_req_q <= expire_w & (ctrl_w.sel == 2'b00);
  end

  assign wdt_rst_o = rst_req_q;
  assign wdt_irq_o = ctrl_w.evt & (ctrl_w.sel != 2'b00);
endmodule

// File: rtl/wdt_locked_chk.sv
module wdt_locked_chk import wdt_pkg::*; #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          stb,
  input logic          we,
  input logic          ack,
  input ctrl_t         ctrl,
  input logic [DW-1:0] tout,
  input logic          rst_o
);
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);                                            // R2
  AST_ACK_FOLLOWS_STB: assert property (@(posedge clk) disable iff (rst)
    (stb && !ack) |=> ack);                                   // R2
  AST_TOUT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ctrl.en |=> $stable(tout));                               // R3
  AST_MODES_FROZEN: assert property (@(posedge clk) disable iff (rst)
    ctrl.en |=> $stable({ctrl.sel, ctrl.rdbg, ctrl.rstop, ctrl.rwait})); // R3
  AST_WP_HOLDS_EN: assert property (@(posedge clk) disable iff (rst)
    ctrl.wprot |=> $stable(ctrl.en));                         // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    ctrl.lock |=> (ctrl.lock && $stable(ctrl.wprot)));        // R6
  AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ctrl.evt && !(stb && !ack && we)) |=> ctrl.evt);         // R11
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
    rst_o |=> !rst_o);                                        // R14
endmodule

bind wdt_locked wdt_locked_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .stb(bus_stb), .we(bus_we), .ack(bus_ack),
  .ctrl(ctrl_w), .tout(tout_w), .rst_o(wdt_rst_o)
);

// File: tb/test_wdt_locked.sv
module test_wdt_locked;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_stb = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_adr = 2'd0;
  logic [15:0] bus_wdat = 16'h0;
  logic [15:0] bus_rdat;
  logic        bus_ack;
  logic        osc = 1'b0, wait_i = 1'b0, stop_i = 1'b0, dbg_i = 1'b0;
  logic        wdt_rst_o, wdt_irq_o;

  int n_chk = 0, n_err = 0, rst_pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  wdt_locked i_wdt_locked (
    .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_we(bus_we), .bus_adr(bus_adr),
    .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .bus_ack(bus_ack), .osc_i(osc),
    .wait_i(wait_i), .stop_i(stop_i), .dbg_i(dbg_i),
    .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_ctrl, m_tout, m_cnt, m_rdat;
  logic        m_pend, m_arm, m_ack, m_rsto;
  logic [2:0]  m_osc;

  always @(posedge clk) begin
    logic tick, acc, step, expire, svc, reload;
    logic [15:0] nctrl;
    if (rst) begin
      m_ctrl = 16'h0004; m_tout = 16'hFFFF; m_cnt = 16'hFFFF; m_rdat = 16'h0;
      m_pend = 1'b1; m_arm = 1'b0; m_ack = 1'b0; m_rsto = 1'b0; m_osc = 3'b0;
    end else begin
      tick  = m_osc[1] && !m_osc[2];
      m_osc = {m_osc[1:0], osc};
      acc   = bus_stb && !m_ack;
      step  = tick && m_ctrl[2] && !((wait_i && !m_ctrl[3]) ||
              (stop_i && !m_ctrl[4]) || (dbg_i && !m_ctrl[5]));
      expire = step && !m_pend && (m_cnt == 16'h0);
      svc    = acc && bus_we && bus_adr == 2'd2 && m_arm && bus_wdat == 16'hAAAA;
      if (acc && !bus_we)
        m_rdat = (bus_adr == 2'd0) ? m_ctrl : (bus_adr == 2'd1) ? m_tout :
                 (bus_adr == 2'd2) ? m_cnt : 16'h0;
      nctrl = m_ctrl;
      if (acc && bus_we && bus_adr == 2'd0) begin
        if (bus_wdat[0]) nctrl[0] = 1'b1;
        if (!m_ctrl[0])  nctrl[1] = bus_wdat[1];
        if (!m_ctrl[1])  nctrl[2] = bus_wdat[2];
        if (!m_ctrl[2])  nctrl[7:3] = bus_wdat[7:3];
        if (bus_wdat[8]) nctrl[8] = 1'b0;
      end
      if (svc)    nctrl[8] = 1'b0;
      if (expire) nctrl[8] = 1'b1;
      reload = (nctrl[2] && !m_ctrl[2]) || svc;
      if (step) m_cnt = (m_pend || m_cnt == 16'h0) ? m_tout : m_cnt - 16'h1;
      if (reload) m_pend = 1'b1; else if (step) m_pend = 1'b0;
      if (acc && bus_we && bus_adr == 2'd1 && !m_ctrl[2]) m_tout = bus_wdat;
      if (acc && bus_we && bus_adr == 2'd2) m_arm = (bus_wdat == 16'h5555);
      m_rsto = expire && (m_ctrl[7:6] == 2'b00);
      m_ack  = acc;
      m_ctrl = nctrl;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check("MODEL ack (R2)", {15'h0, bus_ack}, {15'h0, m_ack});
      if (bus_ack) check("MODEL rdata (R2)", bus_rdat, m_rdat);
      check("MODEL rst_o (R14)", {15'h0, wdt_rst_o}, {15'h0, m_rsto});
      check("MODEL irq_o (R13)", {15'h0, wdt_irq_o},
            {15'h0, m_ctrl[8] && (m_ctrl[7:6] != 2'b00)});
      if (wdt_rst_o) rst_pulses++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_adr = a; bus_wdat = d; bus_we = 1'b1; bus_stb = 1'b1;
    @(negedge clk);
    bus_stb = 1'b0; bus_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    bus_adr = a; bus_we = 1'b0; bus_stb = 1'b1;
    @(negedge clk);
    check(tag, bus_rdat, exp);
    bus_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      osc = 1'b1; repeat (3) @(negedge clk);
      osc = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0; @(negedge clk);
  endtask

  initial begin
    int base;
    do_reset();
    rd(0, 16'h0004, "R1 ctrl reset");
    rd(1, 16'hFFFF, "R1 tout reset");
    rd(2, 16'hFFFF, "R1 count reset");
    // R3: enabled, configuration frozen
    wr(1, 16'h1234); rd(1, 16'hFFFF, "R3 tout frozen");
    wr(0, 16'h003C); rd(0, 16'h0004, "R3 modes frozen");
    // R4: disabled, configuration writable
    wr(0, 16'h0000); wr(0, 16'h0038); rd(0, 16'h0038, "R4 modes written");
    wr(1, 16'h0005); rd(1, 16'h0005, "R4 tout written");
    // R5: write protect holds enable
    wr(0, 16'h0006); rd(0, 16'h0006, "R5 wp+en set");
    wr(0, 16'h0000); rd(0, 16'h0004, "R5 wp cleared, en kept");
    wr(0, 16'h0000); rd(0, 16'h0000, "R5 en cleared later");
    // R7: count not writable
    wr(2, 16'h0000); rd(2, 16'hFFFF, "R7 count unchanged");
    // R6: lock freezes write protect until reset
    wr(0, 16'h0003); rd(0, 16'h0003, "R6 lock+wp set");
    wr(0, 16'h0000); rd(0, 16'h0003, "R6 clear attempt");
    wr(0, 16'h0004); rd(0, 16'h0003, "R6 enable blocked");
    do_reset();      rd(0, 16'h0004, "R6 reset clears lock");
    // R8: load then decrement
    wr(0, 16'h0000); wr(1, 16'h5555); wr(0, 16'h0004);
    pulses(1); rd(2, 16'h5555, "R8 first tick loads");
    pulses(5); rd(2, 16'h5550, "R8 decrement");
    // R9: service sequence
    wr(2, 16'h5555); wr(2, 16'hAAAA);
    pulses(1); rd(2, 16'h5555, "R9 service reload");
    wr(2, 16'h5555); wr(2, 16'h1234); wr(2, 16'hAAAA);
    pulses(1); rd(2, 16'h5554, "R9 broken sequence");
    // R10: enable toggle reloads
    wr(0, 16'h0000); wr(0, 16'h0004);
    pulses(1); rd(2, 16'h5555, "R10 toggle reload");
    // R11 / R14: expiry, sticky flag, reset pulse
    wr(0, 16'h0000); wr(1, 16'h0005); wr(0, 16'h0004);
    base = rst_pulses;
    pulses(9); rd(0, 16'h0104, "R11 event set");
    rd(2, 16'h0003, "R11 reload after expiry");
    check("R14 one reset pulse", 16'(rst_pulses - base), 16'h1);
    wr(0, 16'h0104); rd(0, 16'h0004, "R11 write-one clears");
    pulses(4); rd(0, 16'h0104, "R11 second expiry");
    pulses(2); rd(0, 16'h0104, "R11 flag sticky");
    wr(2, 16'h5555); wr(2, 16'hAAAA); rd(0, 16'h0004, "R9 service clears flag");
    // R12: pause inputs
    wr(0, 16'h0000); wr(1, 16'h0100); wr(0, 16'h0004);
    pulses(1); rd(2, 16'h0100, "R12 loaded");
    wait_i = 1'b1; pulses(3); wait_i = 1'b0; rd(2, 16'h0100, "R12 wait pauses");
    dbg_i = 1'b1; pulses(2); dbg_i = 1'b0;   rd(2, 16'h0100, "R12 debug pauses");
    wr(0, 16'h0000); wr(0, 16'h000C);
    pulses(1); wait_i = 1'b1; pulses(2); wait_i = 1'b0;
    rd(2, 16'h00FE, "R12 run-in-wait counts");
    stop_i = 1'b1; pulses(1); stop_i = 1'b0; rd(2, 16'h00FE, "R12 stop pauses");
    // R13: interrupt select
    wr(0, 16'h0000); wr(1, 16'h0002); wr(0, 16'h0044);
    check("R13 irq low before", {15'h0, wdt_irq_o}, 16'h0);
    base = rst_pulses;
    pulses(4);
    check("R13 irq high on expiry", {15'h0, wdt_irq_o}, 16'h1);
    check("R13 no reset pulse", 16'(rst_pulses - base), 16'h0);
    rd(0, 16'h0144, "R13 ctrl with event");
    wr(0, 16'h0144);
    check("R13 irq cleared", {15'h0, wdt_irq_o}, 16'h0);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule